// File: doc/BRIEF.md
# Four-Point Inverse Sine Transform Lane

This block takes four signed 16-bit coefficients and returns four signed 16-bit samples of a 4-point inverse asymmetric discrete sine transform. The arithmetic uses four fixed Q14 sine constants and follows a fixed product and sum schedule. That schedule has seven constant products and one extra term. The extra term adds and subtracts three inputs at full width and then scales the result by a single constant. Each of the four results is rounded at half an LSB, shifted down by 14 bits and narrowed to 16 bits. The narrowing wraps and never saturates.

The lane interface is one valid strobe plus four input words and four output words. A two-dimensional controller can therefore put this lane in the place of a 4-point inverse cosine lane with the same pipelining option and latency. A parameter decides whether the products get their own register stage. The output stage is always registered, so the latency is one or two cycles.

Top module: `iadst4_lane`

## Requirements
- R1: With Q14 constants c1=5283, c2=9929, c3=13377 and c4=15212, y0 equals rnd(c1·x0 + c3·x1 + c4·x2 + c2·x3).
- R2: y1 equals rnd(c2·x0 + c3·x1 − c1·x2 − c4·x3).
- R3: y2 equals rnd(c3·(x0 − x2 + x3)), where the inner sum is formed at full width with no 16-bit wrap.
- R4: y3 equals rnd((c1+c2)·x0 − c3·x1 + (c4−c1)·x2 + (c2−c4)·x3).
- R5: rnd(v) adds 8192 to v and then shifts arithmetically right by 14. It rounds half toward plus infinity, so a value v in [−8192, 8191] gives 0.
- R6: The rounded result keeps only its low 16 bits, read as two's complement, with no saturation.
- R7: out_vld is high exactly LAT = 1 + PIPE_MUL cycles after each cycle in which in_vld is high, and low otherwise.
- R8: When out_vld is low, y0..y3 hold their last values, whatever the inputs do.
- R9: While rst_n is low, out_vld and y0..y3 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input coefficients valid |
| in_x0 | input | 16 | Coefficient 0, signed |
| in_x1 | input | 16 | Coefficient 1, signed |
| in_x2 | input | 16 | Coefficient 2, signed |
| in_x3 | input | 16 | Coefficient 3, signed |
| out_vld | output | 1 | Output samples valid |
| out_y0 | output | 16 | Sample 0, signed |
| out_y1 | output | 16 | Sample 1, signed |
| out_y2 | output | 16 | Sample 2, signed |
| out_y3 | output | 16 | Sample 3, signed |

## Verification
Single-coefficient vectors such as +1 and −1 on x0 or x1 show each constant's place in each output. They also show round-half-up apart from truncation, because c1 rounds to 0 while c2 and c4 round to ±1. Extreme vectors with mixed signs drive y3 past 16 bits, which shows wrap apart from saturation. The vector with x0 and x3 at +32767 and x2 at −32768 shows whether the side term is formed at full width or wraps at 16 bits. Back-to-back strobes and idle cycles with changing inputs show the latency and that the outputs hold.

// File: rtl/iadst4_pkg.sv
package iadst4_pkg;
  parameter int unsigned LANE_W = 16;
  parameter int unsigned FRAC   = 14;
  localparam int unsigned ACC_W = 2 * LANE_W;

  typedef logic signed [LANE_W-1:0] lane_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // Q14 sine constants
  localparam lane_t SIN1 = 16'sh14A3;
  localparam lane_t SIN2 = 16'sh26C9;
  localparam lane_t SIN3 = 16'sh3441;
  localparam lane_t SIN4 = 16'sh3B6C;

  typedef struct packed {
    acc_t m0;  // SIN1*x0
    acc_t m1;  // SIN2*x0
    acc_t m2;  // SIN3*x1
    acc_t m3;  // SIN4*x2
    acc_t m4;  // SIN1*x2
    acc_t m5;  // SIN2*x3
    acc_t m6;  // SIN4*x3
    acc_t ms;  // SIN3*(x0-x2+x3)
  } prod_t;

  function automatic acc_t qmul(input lane_t c, input lane_t x);
    acc_t cw, xw;
    cw = acc_t'(c);
    xw = acc_t'(x);
    return cw * xw;
  endfunction

  // full-width side term, scaled by SIN3, low ACC_W bits kept
  function automatic acc_t side_term(input lane_t x0, input lane_t x2, input lane_t x3);
    acc_t tw;
    tw = acc_t'(x0) - acc_t'(x2) + acc_t'(x3);
    return tw * acc_t'(SIN3);
  endfunction

  function automatic lane_t round_narrow(input acc_t v);
    acc_t r;
    acc_t s;
    r = v + (acc_t'(1) <<< (FRAC - 1));
    s = r >>> FRAC;
    return lane_t'(s[LANE_W-1:0]);
  endfunction
endpackage

// File: rtl/iadst4_mul.sv
module iadst4_mul
  import iadst4_pkg::*;
#(
  parameter bit PIPE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vld_i,
  input  lane_t x0_i,
  input  lane_t x1_i,
  input  lane_t x2_i,
  input  lane_t x3_i,
  output logic  vld_o,
  output prod_t prod_o
);
  prod_t prod_c;

  always_comb begin
    prod_c.m0 = qmul(SIN1, x0_i);
    prod_c.m1 = qmul(SIN2, x0_i);
    prod_c.m2 = qmul(SIN3, x1_i);
    prod_c.m3 = qmul(SIN4, x2_i);
    prod_c.m4 = qmul(SIN1, x2_i);
    prod_c.m5 = qmul(SIN2, x3_i);
    prod_c.m6 = qmul(SIN4, x3_i);
    prod_c.ms = side_term(x0_i, x2_i, x3_i);
  end

  generate
    if (PIPE) begin : g_reg
      prod_t prod_q;
      logic  vld_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          prod_q <= '0;
        end else begin
          vld_q <= vld_i;
          if (vld_i) prod_q <= prod_c;
        end
      end
      assign vld_o  = vld_q;
      assign prod_o = prod_q;

      // R3: equal x0 and x2 with x3 zero cancels the side term
      a_r3_side_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && x0_i == x2_i && x3_i == '0) |=> (prod_o.ms == '0));
    end else begin : g_comb
      assign vld_o  = vld_i;
      assign prod_o = prod_c;
    end
  endgenerate
endmodule

// File: rtl/iadst4_sum_round.sv
module iadst4_sum_round
  import iadst4_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vld_i,
  input  prod_t prod_i,
  output logic  vld_o,
  output lane_t y0_o,
  output lane_t y1_o,
  output lane_t y2_o,
  output lane_t y3_o
);
  acc_t sum_a, sum_b;
  acc_t pre0, pre1, pre2, pre3;

  always_comb begin
    sum_a = prod_i.m0 + prod_i.m3 + prod_i.m5;
    sum_b = prod_i.m1 - prod_i.m4 - prod_i.m6;
    pre0  = sum_a + prod_i.m2;
    pre1  = sum_b + prod_i.m2;
    pre2  = prod_i.ms;
    pre3  = sum_a + sum_b - prod_i.m2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      y0_o  <= '0;
      y1_o  <= '0;
      y2_o  <= '0;
      y3_o  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        y0_o <= round_narrow(pre0);
        y1_o <= round_narrow(pre1);
        y2_o <= round_narrow(pre2);
        y3_o <= round_narrow(pre3);
      end
    end
  end

  // R5: anything below half a step in magnitude rounds to zero
  logic small0, small3;
  assign small0 = (pre0 >= -acc_t'(8192)) && (pre0 <= acc_t'(8191));
  assign small3 = (pre3 >= -acc_t'(8192)) && (pre3 <= acc_t'(8191));

  a_r5_small_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && small0 && small3) |=> (y0_o == '0 && y3_o == '0));
endmodule

// File: rtl/iadst4_lane.sv
module iadst4_lane
  import iadst4_pkg::*;
#(
  parameter bit PIPE_MUL = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  logic signed [LANE_W-1:0]  in_x0,
  input  logic signed [LANE_W-1:0]  in_x1,
  input  logic signed [LANE_W-1:0]  in_x2,
  input  logic signed [LANE_W-1:0]  in_x3,
  output logic                      out_vld,
  output logic signed [LANE_W-1:0]  out_y0,
  output logic signed [LANE_W-1:0]  out_y1,
  output logic signed [LANE_W-1:0]  out_y2,
  output logic signed [LANE_W-1:0]  out_y3
);
  localparam int unsigned LAT = 1 + int'(PIPE_MUL);

  logic  mid_vld;
  prod_t mid_prod;

  iadst4_mul #(.PIPE(PIPE_MUL)) i_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (in_vld),
    .x0_i   (in_x0),
    .x1_i   (in_x1),
    .x2_i   (in_x2),
    .x3_i   (in_x3),
    .vld_o  (mid_vld),
    .prod_o (mid_prod)
  );

  iadst4_sum_round i_sum (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (mid_vld),
    .prod_i (mid_prod),
    .vld_o  (out_vld),
    .y0_o   (out_y0),
    .y1_o   (out_y1),
    .y2_o   (out_y2),
    .y3_o   (out_y3)
  );

  generate
    if (LAT == 2) begin : g_lat2
      a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ##1 out_vld);
      a_r7_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ##1 !out_vld);
    end else begin : g_lat1
      a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
      a_r7_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    end
  endgenerate

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> ($stable(out_y0) && $stable(out_y1) && $stable(out_y2) && $stable(out_y3)));
endmodule

// File: tb/test_iadst4_lane.sv
module test_iadst4_lane;
  localparam int CLK_NS = 4;
  localparam bit PIPE   = 1'b1;
  localparam int LAT    = 1 + int'(PIPE);
  localparam int NV     = 10;
  // each entry {x3, x2, x1, x0}
  localparam logic [63:0] VEC [NV] = '{
    64'h0000_0000_0000_0000,
    64'h0000_0000_0000_0001,
    64'h0000_0000_0000_FFFF,
    64'h0000_0000_0001_0000,
    64'h0001_0000_0000_0000,
    64'h0064_FF38_012C_FE70,
    64'h7FFF_7FFF_7FFF_7FFF,
    64'h8000_7FFF_8000_7FFF,
    64'h7FFF_8000_0000_7FFF,
    64'h8000_8000_8000_8000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic signed [15:0] in_x0 = '0, in_x1 = '0, in_x2 = '0, in_x3 = '0;
  logic out_vld;
  logic signed [15:0] out_y0, out_y1, out_y2, out_y3;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  iadst4_lane #(.PIPE_MUL(PIPE)) i_iadst4_lane (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .in_x0(in_x0), .in_x1(in_x1), .in_x2(in_x2), .in_x3(in_x3),
    .out_vld(out_vld),
    .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2), .out_y3(out_y3)
  );

  // model: row-wise coefficient form, 64-bit exact
  function automatic logic [15:0] model(input int k, input logic [63:0] v);
    longint x0, x1, x2, x3, acc;
    x0 = longint'($signed(v[15:0]));
    x1 = longint'($signed(v[31:16]));
    x2 = longint'($signed(v[47:32]));
    x3 = longint'($signed(v[63:48]));
    case (k)
      0: acc = 5283*x0 + 13377*x1 + 15212*x2 + 9929*x3;
      1: acc = 9929*x0 + 13377*x1 - 5283*x2 - 15212*x3;
      2: acc = 13377*(x0 - x2 + x3);
      default: acc = 15212*x0 - 13377*x1 + 9929*x2 - 5283*x3;
    endcase
    acc = (acc + 8192) >>> 14;
    return acc[15:0];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, $signed(act), $signed(exp));
    end
  endtask

  task automatic drive(input logic [63:0] v, input logic vld);
    in_x0 = v[15:0]; in_x1 = v[31:16]; in_x2 = v[47:32]; in_x3 = v[63:48];
    in_vld = vld;
  endtask

  task automatic check_outs(input logic [63:0] v, input string note);
    chk({"R1 y0 ", note}, out_y0, model(0, v));
    chk({"R2 y1 ", note}, out_y1, model(1, v));
    chk({"R3 y2 ", note}, out_y2, model(2, v));
    chk({"R4 y3 ", note}, out_y3, model(3, v));
  endtask

  task automatic run_vec(input logic [63:0] v, input string note);
    @(negedge clk) drive(v, 1'b1);
    @(negedge clk) drive(~v, 1'b0);
    for (int i = 1; i < LAT; i++) begin
      chk("R7 out_vld early", {15'd0, out_vld}, 16'd0);
      @(negedge clk);
    end
    chk("R7 out_vld on time", {15'd0, out_vld}, 16'd1);
    check_outs(v, note);
    @(negedge clk);
    chk("R7 out_vld single", {15'd0, out_vld}, 16'd0);
  endtask

  initial begin : watchdog
    #(CLK_NS * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 out_vld reset", {15'd0, out_vld}, 16'd0);
    chk("R9 y0 reset", out_y0, 16'd0);
    chk("R9 y3 reset", out_y3, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], "table");

    // R5: rounding, +1 and -1 on x0 (c1 -> 0, c2 -> +/-1)
    run_vec(64'h0000_0000_0000_0001, "R5 plus one");
    chk("R5 y0 rounds down", out_y0, 16'd0);
    chk("R5 y1 rounds up", out_y1, 16'd1);
    run_vec(64'h0000_0000_0000_FFFF, "R5 minus one");
    chk("R5 y0 neg rounds to 0", out_y0, 16'd0);
    chk("R5 y1 neg", out_y1, 16'hFFFF);

    // R6: y3 overflows 16 bits and wraps
    run_vec(64'h8000_7FFF_8000_7FFF, "R6 wrap");
    chk("R6 y3 wrapped", out_y3, 16'((1435246027 + 8192) >>> 14));

    // R3: full-width side term, x0-x2+x3 = 98302
    run_vec(64'h7FFF_8000_0000_7FFF, "R3 wide");
    chk("R3 y2 wide sum", out_y2, 16'(((64'sd98302 * 13377) + 8192) >>> 14));

    // R7: back-to-back strobes
    @(negedge clk) drive(VEC[5], 1'b1);
    @(negedge clk) drive(VEC[7], 1'b1);
    @(negedge clk) drive(64'h0, 1'b0);
    chk("R7 back-to-back vld A", {15'd0, out_vld}, 16'd1);
    check_outs(VEC[5], "R7 first");
    @(negedge clk);
    chk("R7 back-to-back vld B", {15'd0, out_vld}, 16'd1);
    check_outs(VEC[7], "R7 second");

    // R8: inputs change with strobe low, outputs hold
    @(negedge clk) drive(VEC[6], 1'b0);
    repeat (3) @(negedge clk) drive(VEC[9], 1'b0);
    chk("R8 vld low", {15'd0, out_vld}, 16'd0);
    check_outs(VEC[7], "R8 hold");

    // R9: reset after activity clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 y1 cleared", out_y1, 16'd0);
    chk("R9 y3 cleared", out_y3, 16'd0);
    chk("R9 vld cleared", {15'd0, out_vld}, 16'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule